// File: doc/BRIEF.md
# Component Video Output Format Multiplexer

This block receives three parallel 8-bit sample streams, called A, B and C, at one sample per clock. It repacks them onto three 8-bit output ports using one of several formats. The formats are full-rate 4:4:4, two 4:2:2 chroma-reduction layouts, two 4:1:1 layouts and two fixed test patterns. In the reduced formats the luma stream on port A passes through at full rate. The two chroma streams are folded onto port B as whole words, nibbles or bit pairs, and port C is released to high impedance. A phase marker tells the receiver which slot of a packing group each word belongs to.

A 3-bit format code is taken only when a sync line rises. While the sync line is low the block is held in full-rate 4:4:4 and its slot counter stays at zero. The captured code takes effect a fixed number of clocks after the rise, and the slot counter restarts at zero when it does, so every packing group begins on a known clock. Each port has its own active-low output enable. The block exposes one enable bit per output line, not tri-state pins, so a surrounding pad ring can drive the pins and floating lines can be observed directly.

Top module: `cvfm_fmt_mux`

## Requirements
- R1: While rst_n is low at a clock edge, all data outputs become 0x00, all enable bits become 0 and phase_o becomes 0; after reset the active format is 4:4:4 and the slot counter is 0.
- R2: At every edge where sync_i is sampled low, the active format returns to 4:4:4 (code 0) and the slot counter returns to 0. mode_i is ignored at every edge except the first edge where sync_i is sampled high after being low.
- R3: The code on mode_i is captured at the first edge where sync_i is sampled high. The first output word in the new format is computed from the samples presented at the fifth edge after the capture edge, and that word uses slot 0. Outputs before that word keep the old format. If sync_i falls before then, the capture is discarded.
- R4: Code 0 (4:4:4), and the unused code 1, register each input onto its own port one edge later, with all 24 lines enabled.
- R5: Code 2 (4:2:2 co-sited) passes A at full rate. On even slots port B carries the current B sample; on odd slots it carries the C sample of the previous (even) slot. Port C is disabled.
- R6: Code 3 (4:2:2 alternate) passes A at full rate. Port B carries the current B sample on even slots and the current C sample on odd slots. Port C is disabled.
- R7: Code 4 (4:1:1) passes A at full rate. Over slots 0 to 3, port B[7:6] carries bit pairs 7:6, 5:4, 3:2, 1:0 of the B sample taken in slot 0, and port B[5:4] carries the same pairs of the slot-0 C sample. B[3:0] and all of port C are disabled.
- R8: Code 5 (4:1:1 alternate) passes A at full rate. Port B[7:4] carries, in order, B[3:0] of the slot-0 sample, B[7:4] of that sample, C[3:0] of the slot-2 sample and C[7:4] of that sample. B[3:0] and port C are disabled.
- R9: Code 6 drives 0xAA on all three ports and code 7 drives 0x55 on all three ports, with all lines enabled.
- R10: A set bit in a_en_o, b_en_o or c_en_o means that line is driven. When a port's active-low enable is high, all 8 of its enable bits are 0 in the same cycle, with no clock involved. Lines the format leaves undriven carry data 0.
- R11: phase_o is 0 on slot 0. It follows slot bit 0 in codes 2 and 3, follows slot bit 1 in codes 4 and 5, and stays 0 in codes 0, 1, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Format sync; low holds 4:4:4, rising edge captures mode_i |
| mode_i | input | 3 | Format code |
| a_i | input | 8 | Channel A (luma) sample |
| b_i | input | 8 | Channel B sample |
| c_i | input | 8 | Channel C sample |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b_n | input | 1 | Port B output enable, active low |
| oe_c_n | input | 1 | Port C output enable, active low |
| a_o | output | 8 | Port A data |
| b_o | output | 8 | Port B data |
| c_o | output | 8 | Port C data |
| a_en_o | output | 8 | Port A per-line drive enable |
| b_en_o | output | 8 | Port B per-line drive enable |
| c_en_o | output | 8 | Port C per-line drive enable |
| phase_o | output | 1 | Slot phase marker |

## Verification
The bench focuses on the format switch. It raises sync and checks that the old layout persists for exactly four more words. A design that is one clock early or late mixes random words from the wrong format and fails the data checks. It also drops sync in the middle of a pending change; a design that keeps the stale capture switches format anyway. In the 4:1:1 layouts a design that reads live samples instead of the slot-0 or slot-2 sample shows wrong bit pairs or nibbles on later slots. Random enable toggling each cycle catches enables that are registered or that leave the disabled lines of port B or C driven.

// File: rtl/cvfm_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the format multiplexer.
// Assumes 8-bit samples; the 4:1:1 bit-pair packing needs exactly 8.
package cvfm_pkg;
    localparam int PIX_W  = 8;
    localparam int NIB    = PIX_W / 2;
    localparam int SLOT_W = 2;
    localparam int PORTS  = 3;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [2:0] {
        FMT_444  = 3'd0,
        FMT_RSV  = 3'd1,
        FMT_D2   = 3'd2,
        FMT_422S = 3'd3,
        FMT_411  = 3'd4,
        FMT_411S = 3'd5,
        FMT_PAT1 = 3'd6,
        FMT_PAT2 = 3'd7
    } fmt_e;

    localparam pix_t PAT_HI   = {NIB{2'b10}};
    localparam pix_t PAT_LO   = {NIB{2'b01}};
    localparam pix_t ALL_ON   = {PIX_W{1'b1}};
    localparam pix_t HIGH_NIB = {{NIB{1'b1}}, {NIB{1'b0}}};

    // Two-bit group k of a sample, most significant group first.
    function automatic logic [1:0] bit_pair(input pix_t v, input slot_t k);
        return v[PIX_W-1-2*int'(k) -: 2];
    endfunction
endpackage

// File: rtl/cvfm_mode_ctl.sv
`timescale 1ns/1ps
// Format control: watches the sync line, captures the code on its rising
// edge and applies it LAT_CLK edges later, restarting the slot counter.
// Assumes LAT_CLK >= 2. Sync low holds the format at 4:4:4.
module cvfm_mode_ctl
    import cvfm_pkg::*;
#(
    parameter int LAT_CLK = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [2:0] code_i,
    output fmt_e       fmt_o,
    output slot_t      slot_o
);
    localparam int DLY_W = $clog2(LAT_CLK + 1);

    logic             sync_q;
    fmt_e             pend_q;
    logic [DLY_W-1:0] dly_q;

    // Sync edge detect, pending-code countdown and slot counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            fmt_o  <= FMT_444;
            pend_q <= FMT_444;
            dly_q  <= '0;
            slot_o <= '0;
        end else begin
            sync_q <= sync_i;
            if (!sync_i) begin
                fmt_o  <= FMT_444;
                dly_q  <= '0;
                slot_o <= '0;
            end else if (!sync_q) begin
                pend_q <= fmt_e'(code_i);
                dly_q  <= DLY_W'(LAT_CLK - 1);
                slot_o <= slot_o + 1'b1;
            end else if (dly_q == DLY_W'(1)) begin
                fmt_o  <= pend_q;
                dly_q  <= '0;
                slot_o <= '0;
            end else begin
                if (dly_q != '0) dly_q <= dly_q - 1'b1;
                slot_o <= slot_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cvfm_pack.sv
`timescale 1ns/1ps
// Packing datapath: builds the three output words, their drive masks and
// the phase marker for the active format and slot, and registers them.
// Keeps the chroma samples that later slots of a group still need.
module cvfm_pack
    import cvfm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  fmt_e  fmt_i,
    input  slot_t slot_i,
    input  pix_t  a_i,
    input  pix_t  b_i,
    input  pix_t  c_i,
    output pix_t  a_o,
    output pix_t  b_o,
    output pix_t  c_o,
    output pix_t  am_o,
    output pix_t  bm_o,
    output pix_t  cm_o,
    output logic  phase_o
);
    pix_t hold_b, hold_c;
    pix_t na, nb, nc, ma, mb, mc;
    pix_t src_b, src_c;
    logic [NIB-1:0] nib;
    logic ph, cap_b, cap_c;

    // Next-word selection per format and slot.
    always_comb begin
        na = a_i;  nb = b_i;  nc = c_i;
        ma = ALL_ON; mb = ALL_ON; mc = ALL_ON;
        ph = 1'b0; cap_b = 1'b0; cap_c = 1'b0;
        src_b = (slot_i == '0) ? b_i : hold_b;
        src_c = (slot_i == '0) ? c_i : hold_c;
        nib = '0;
        case (fmt_i)
            FMT_D2: begin
                nb    = slot_i[0] ? hold_c : b_i;
                nc    = '0;  mc = '0;
                ph    = slot_i[0];
                cap_c = !slot_i[0];
            end
            FMT_422S: begin
                nb = slot_i[0] ? c_i : b_i;
                nc = '0;  mc = '0;
                ph = slot_i[0];
            end
            FMT_411: begin
                nb    = {bit_pair(src_b, slot_i), bit_pair(src_c, slot_i), {NIB{1'b0}}};
                mb    = HIGH_NIB;
                nc    = '0;  mc = '0;
                ph    = slot_i[1];
                cap_b = (slot_i == '0);
                cap_c = (slot_i == '0);
            end
            FMT_411S: begin
                case (slot_i)
                    2'd0:    nib = b_i[NIB-1:0];
                    2'd1:    nib = hold_b[PIX_W-1:NIB];
                    2'd2:    nib = c_i[NIB-1:0];
                    default: nib = hold_c[PIX_W-1:NIB];
                endcase
                nb    = {nib, {NIB{1'b0}}};
                mb    = HIGH_NIB;
                nc    = '0;  mc = '0;
                ph    = slot_i[1];
                cap_b = (slot_i == 2'd0);
                cap_c = (slot_i == 2'd2);
            end
            FMT_PAT1: begin na = PAT_HI; nb = PAT_HI; nc = PAT_HI; end
            FMT_PAT2: begin na = PAT_LO; nb = PAT_LO; nc = PAT_LO; end
            default: ;
        endcase
    end

    // Chroma hold registers for the later slots of a packing group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_b <= '0;
            hold_c <= '0;
        end else begin
            if (cap_b) hold_b <= b_i;
            if (cap_c) hold_c <= c_i;
        end
    end

    // Output word, mask and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o <= '0;  b_o <= '0;  c_o <= '0;
            am_o <= '0; bm_o <= '0; cm_o <= '0;
            phase_o <= 1'b0;
        end else begin
            a_o <= na;  b_o <= nb;  c_o <= nc;
            am_o <= ma; bm_o <= mb; cm_o <= mc;
            phase_o <= ph;
        end
    end
endmodule

// File: rtl/cvfm_oe_gate.sv
`timescale 1ns/1ps
// Per-port enable gate: combines the registered drive mask with the
// port's active-low enable, combinationally, so the enable needs no clock.
module cvfm_oe_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] mask_i,
    input  logic         oe_n_i,
    output logic [W-1:0] en_o
);
    // Release every line while the port enable is high.
    always_comb en_o = oe_n_i ? '0 : mask_i;
endmodule

// File: rtl/cvfm_fmt_mux.sv
`timescale 1ns/1ps
// Top of the component video format multiplexer. Format control sets the
// active format and slot; the packing datapath builds the words; one gate
// per port applies the asynchronous output enable.
module cvfm_fmt_mux
    import cvfm_pkg::*;
#(
    parameter int LAT_CLK = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [2:0] mode_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic [7:0] c_i,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    input  logic       oe_c_n,
    output logic [7:0] a_o,
    output logic [7:0] b_o,
    output logic [7:0] c_o,
    output logic [7:0] a_en_o,
    output logic [7:0] b_en_o,
    output logic [7:0] c_en_o,
    output logic       phase_o
);
    fmt_e       fmt_q;
    slot_t      slot_q;
    logic [2:0] fmt_now;
    pix_t       mask [PORTS];
    pix_t       en   [PORTS];
    logic       oe_n [PORTS];

    assign fmt_now = fmt_q;

    cvfm_mode_ctl #(.LAT_CLK(LAT_CLK)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .code_i(mode_i),
        .fmt_o(fmt_q), .slot_o(slot_q)
    );

    cvfm_pack u_pack (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_q), .slot_i(slot_q),
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .a_o(a_o), .b_o(b_o), .c_o(c_o),
        .am_o(mask[0]), .bm_o(mask[1]), .cm_o(mask[2]),
        .phase_o(phase_o)
    );

    assign oe_n[0] = oe_a_n;
    assign oe_n[1] = oe_b_n;
    assign oe_n[2] = oe_c_n;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        cvfm_oe_gate #(.W(PIX_W)) u_gate (
            .mask_i(mask[p]), .oe_n_i(oe_n[p]), .en_o(en[p])
        );
    end

    assign a_en_o = en[0];
    assign b_en_o = en[1];
    assign c_en_o = en[2];
endmodule

// File: rtl/cvfm_chk.sv
`timescale 1ns/1ps
// Assertion checker for cvfm_fmt_mux, attached by bind below.
module cvfm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_i,
    input logic [2:0] fmt_now,
    input logic [7:0] a_i,
    input logic [7:0] a_o,
    input logic       oe_b_n,
    input logic [7:0] b_en_o,
    input logic [7:0] c_en_o,
    input logic       phase_o
);
    p_sync_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> (fmt_now == 3'd0));

    p_pass_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now == 3'd0) |=> (a_o == $past(a_i)));

    p_c_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now inside {3'd2, 3'd3, 3'd4, 3'd5}) |=> (c_en_o == 8'h00));

    p_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now == 3'd6) |=> (a_o == 8'hAA));

    p_oe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b_n |-> (b_en_o == 8'h00));

    p_phase_flat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now inside {3'd0, 3'd1, 3'd6, 3'd7}) |=> !phase_o);
endmodule

bind cvfm_fmt_mux cvfm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .fmt_now(fmt_now),
    .a_i(a_i), .a_o(a_o), .oe_b_n(oe_b_n), .b_en_o(b_en_o),
    .c_en_o(c_en_o), .phase_o(phase_o)
);

// File: tb/tb_cvfm_fmt_mux.sv
`timescale 1ns/1ps
module tb_cvfm_fmt_mux;
    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic [7:0] a_i = '0, b_i = '0, c_i = '0;
    logic oe_a_n = 1'b0, oe_b_n = 1'b0, oe_c_n = 1'b0;
    logic [7:0] a_o, b_o, c_o, a_en_o, b_en_o, c_en_o;
    logic phase_o;

    int total = 0;
    int bad = 0;
    string scen = "";

    // model state
    int m_mode = 0, m_slot = 0, m_pend = 0, m_dly = 0;
    bit m_sq = 1'b0;
    logic [7:0] hb [1:3];
    logic [7:0] hc [1:3];
    logic [7:0] ea, eb, ec, ema, emb, emc;
    logic ep;

    always #5 clk = ~clk;

    cvfm_fmt_mux #(.LAT_CLK(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode_i(mode_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c_n(oe_c_n),
        .a_o(a_o), .b_o(b_o), .c_o(c_o),
        .a_en_o(a_en_o), .b_en_o(b_en_o), .c_en_o(c_en_o),
        .phase_o(phase_o)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic string mtag(input int m);
        case (m)
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6, 7: return "R9";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [1:0] pair(input logic [7:0] v, input int k);
        return v[7-2*k -: 2];
    endfunction

    // Expected outputs for the coming edge, from the requirements.
    task automatic model_out();
        logic [7:0] sb, sc;
        ea = a_i; eb = b_i; ec = c_i;
        ema = 8'hFF; emb = 8'hFF; emc = 8'hFF; ep = 1'b0;
        sb = (m_slot == 0) ? b_i : hb[m_slot];
        sc = (m_slot == 0) ? c_i : hc[m_slot];
        case (m_mode)
            2: begin eb = (m_slot % 2) ? hc[1] : b_i; ec = 0; emc = 0; ep = m_slot[0]; end
            3: begin eb = (m_slot % 2) ? c_i : b_i; ec = 0; emc = 0; ep = m_slot[0]; end
            4: begin
                eb = {pair(sb, m_slot), pair(sc, m_slot), 4'h0};
                emb = 8'hF0; ec = 0; emc = 0; ep = m_slot[1];
            end
            5: begin
                case (m_slot)
                    0: eb = {b_i[3:0], 4'h0};
                    1: eb = {hb[1][7:4], 4'h0};
                    2: eb = {c_i[3:0], 4'h0};
                    default: eb = {hc[1][7:4], 4'h0};
                endcase
                emb = 8'hF0; ec = 0; emc = 0; ep = m_slot[1];
            end
            6: begin ea = 8'hAA; eb = 8'hAA; ec = 8'hAA; end
            7: begin ea = 8'h55; eb = 8'h55; ec = 8'h55; end
            default: ;
        endcase
    endtask

    task automatic model_update();
        hb[3] = hb[2]; hb[2] = hb[1]; hb[1] = b_i;
        hc[3] = hc[2]; hc[2] = hc[1]; hc[1] = c_i;
        if (!sync_i) begin
            m_mode = 0; m_slot = 0; m_dly = 0;
        end else if (!m_sq) begin
            m_pend = int'(mode_i); m_dly = LAT - 1; m_slot = (m_slot + 1) % 4;
        end else if (m_dly == 1) begin
            m_mode = m_pend; m_dly = 0; m_slot = 0;
        end else begin
            if (m_dly != 0) m_dly--;
            m_slot = (m_slot + 1) % 4;
        end
        m_sq = sync_i;
    endtask

    // One clock: drive at negedge, check after the edge, advance the model.
    task automatic step(input bit s, input int code);
        string t;
        @(negedge clk);
        sync_i = s;
        a_i = 8'($urandom); b_i = 8'($urandom); c_i = 8'($urandom);
        mode_i = (code < 0) ? 3'($urandom % 8) : 3'(code);
        oe_a_n = ($urandom % 4) == 0;
        oe_b_n = ($urandom % 4) == 0;
        oe_c_n = ($urandom % 4) == 0;
        model_out();
        t = $sformatf("%s %s mode=%0d slot=%0d", scen, mtag(m_mode), m_mode, m_slot);
        @(posedge clk); #1;
        chk({t, " a_o"}, a_o, ea);
        chk({t, " b_o"}, b_o, eb);
        chk({t, " c_o"}, c_o, ec);
        chk({t, " R10 a_en_o"}, a_en_o, oe_a_n ? 8'h00 : ema);
        chk({t, " R10 b_en_o"}, b_en_o, oe_b_n ? 8'h00 : emb);
        chk({t, " R10 c_en_o"}, c_en_o, oe_c_n ? 8'h00 : emc);
        chk({t, " R11 phase_o"}, {7'd0, phase_o}, {7'd0, ep});
        model_update();
    endtask

    // Sync low for a while, then rise with a code and stay high.
    task automatic run_fmt(input int code, input int low_n, input int high_n);
        for (int i = 0; i < low_n; i++) step(1'b0, -1);
        step(1'b1, code);
        for (int i = 1; i < high_n; i++) step(1'b1, -1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int order [9] = '{2, 3, 4, 5, 6, 7, 1, 0, 4};
        void'($urandom(32'h00C0_FFEE));
        for (int i = 1; i <= 3; i++) begin hb[i] = '0; hc[i] = '0; end
        // R1: reset state, even with random inputs and enables low
        repeat (3) begin
            @(negedge clk);
            a_i = 8'($urandom); b_i = 8'($urandom); c_i = 8'($urandom);
            sync_i = 1'b1; mode_i = 3'd6;
        end
        @(posedge clk); #1;
        chk("R1 reset a_o", a_o, 8'h00);
        chk("R1 reset b_o", b_o, 8'h00);
        chk("R1 reset c_o", c_o, 8'h00);
        chk("R1 reset a_en_o", a_en_o, 8'h00);
        chk("R1 reset b_en_o", b_en_o, 8'h00);
        chk("R1 reset c_en_o", c_en_o, 8'h00);
        chk("R1 reset phase_o", {7'd0, phase_o}, 8'h00);
        rst_n = 1'b1;
        // R2: sync low holds 4:4:4 whatever mode_i does
        scen = "R2 sync-low hold";
        for (int i = 0; i < 20; i++) step(1'b0, -1);
        // R3: each format entered through a sync rise, latency tracked
        scen = "R3 format switch";
        foreach (order[i]) run_fmt(order[i], 2, 40);
        // R3: rise with code 5, then drop early: capture discarded
        scen = "R3 cancelled capture";
        run_fmt(5, 2, 3);
        for (int i = 0; i < 12; i++) step(1'b0, -1);
        // R2: sync rising straight from a previous high-phase format
        scen = "R2 re-sync";
        run_fmt(4, 1, 9);
        run_fmt(2, 1, 11);
        // random sync bursts and codes
        scen = "random";
        for (int n = 0; n < 60; n++)
            run_fmt(int'($urandom % 8), 1 + int'($urandom % 3), 2 + int'($urandom % 30));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule